// File: doc/BRIEF.md
# DMA Channel Command-Port Register File

This block is the programming front end of a multi-channel DMA engine. Software reaches it through two byte-wide ports. A command byte names an operation and a channel. A following stream of bytes on a separate data port carries that command's parameters. A byte pointer inside the block steps through the parameter bytes, so no channel register has an address of its own.

For each channel the block keeps a 24-bit memory address, a 16-bit transfer count, a 16-bit I/O port number, a mode byte and a mask bit. It presents all of them to the transfer engine next to it. The engine sees a per-channel enable, the decoded mode fields and the flattened register values. The address and the count can be read back through the data port, low byte first.

The status, arbitration and master-clear codes belong to other logic. So do the unused codes. This block accepts them and does nothing with them.

Top module: `dmacmd_regfile`

## Requirements
- R1: After reset every channel is masked (`ch_enable` all zero), every address, count, port and mode register is zero, `prog_err` is low and `dat_rdata` is zero.
- R2: A command byte is decoded as operation in bits 7:4 and channel in bits 3:0. Every command byte returns the byte pointer to the first parameter byte. When `cmd_we` and `dat_we` are high in the same cycle, the command is taken and the data byte is dropped.
- R3: Operation 0x2 takes three data bytes into the channel address, in the order bits 7:0, then 15:8, then 23:16.
- R4: Operation 0x4 takes two data bytes into the channel count, low byte then high byte. The value is stored as written (transfer units minus one), so 0xFFFF, which stands for 65536 units, reads back as 0xFFFF.
- R5: Operation 0x0 takes two data bytes into the channel I/O port number, low byte then high byte.
- R6: Operation 0x7 takes one data byte into the channel mode. The decoded outputs are: bit 2 is transfer request (`mode_xfer`), bit 3 is read direction (`mode_read`, clear means write), bit 0 is I/O-register peer (`mode_io`) and bit 6 is 16-bit units (`mode_wide`).
- R7: Operation 0x9 masks the named channel (its `ch_enable` bit drops). Operation 0xA unmasks it (its `ch_enable` bit rises). Each takes effect one clock after the command byte.
- R8: After operation 0x3, `dat_rdata` shows the address byte at the pointer: bits 7:0, then 15:8, then 23:16. Each `dat_re` advances the pointer. Once all three bytes are read, `dat_rdata` is zero.
- R9: After operation 0x5, `dat_rdata` shows the count, low byte then high byte, and `dat_re` advances the pointer. After both bytes, `dat_rdata` is zero.
- R10: Data-port writes that arrive after the current command has taken all of its bytes change nothing.
- R11: Parameter writes to a channel that is not masked are still stored. They also set the sticky flag `prog_err`, which only reset clears. Writes to a masked channel leave `prog_err` unchanged.
- R12: Operations 0x1, 0x6, 0x8 and 0xB to 0xF, and any channel number at or above NCH, change no channel state. They take no data bytes, and while one of them is current `dat_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Command byte: operation 7:4, channel 3:0 |
| dat_we | input | 1 | Data-port write strobe |
| dat_wdata | input | 8 | Data-port write byte |
| dat_re | input | 1 | Data-port read strobe (advances pointer) |
| dat_rdata | output | 8 | Data-port read byte at current pointer |
| ch_enable | output | NCH | Per-channel enable (not masked) |
| mode_xfer | output | NCH | Mode bit 2: transfer request |
| mode_read | output | NCH | Mode bit 3: read direction |
| mode_io | output | NCH | Mode bit 0: I/O-register peer |
| mode_wide | output | NCH | Mode bit 6: 16-bit units |
| ch_addr | output | NCH*24 | Channel addresses, channel g at bits g*24 upward |
| ch_count | output | NCH*16 | Channel counts (units minus one) |
| ch_ioport | output | NCH*16 | Channel I/O port numbers |
| prog_err | output | 1 | Sticky: a parameter was written while its channel was enabled |

## Verification
The bench first reads past the end of each readback stream and expects zero. A design whose pointer does not stop would instead wrap around and return stale address bytes. It then writes an extra count byte after the stream is done; a design that ignores the length would corrupt the high count byte. To catch a pointer that survives a new command, it restarts an address load partway through and expects the middle byte to be unchanged. It also sends a command and a data byte in the same cycle and expects the data byte to be dropped; a design that gave priority the other way would store it in the wrong place. Last, it sends unsupported opcodes followed by data writes, which a sloppy decoder would store into some register.

// File: rtl/dmacmd_regfile.sv
module dmacmd_regfile #(
  parameter int NCH = 16,
  parameter int AW  = 24,
  parameter int CW  = 16,
  parameter int PW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_data,
  input  logic              dat_we,
  input  logic [7:0]        dat_wdata,
  input  logic              dat_re,
  output logic [7:0]        dat_rdata,
  output logic [NCH-1:0]    ch_enable,
  output logic [NCH-1:0]    mode_xfer,
  output logic [NCH-1:0]    mode_read,
  output logic [NCH-1:0]    mode_io,
  output logic [NCH-1:0]    mode_wide,
  output logic [NCH*AW-1:0] ch_addr,
  output logic [NCH*CW-1:0] ch_count,
  output logic [NCH*PW-1:0] ch_ioport,
  output logic              prog_err
);
  localparam logic [3:0] OP_PORT = 4'h0, OP_ADDR = 4'h2, OP_RADDR = 4'h3,
                         OP_CNT  = 4'h4, OP_RCNT = 4'h5, OP_MODE  = 4'h7,
                         OP_MASK = 4'h9, OP_UNMASK = 4'hA;

  function automatic logic [1:0] op_len(input logic [3:0] op);
    case (op)
      OP_ADDR, OP_RADDR:         op_len = 2'd3;
      OP_PORT, OP_CNT, OP_RCNT:  op_len = 2'd2;
      OP_MODE:                   op_len = 2'd1;
      default:                   op_len = 2'd0;
    endcase
  endfunction

  logic [3:0]     op_q, ch_q;
  logic [1:0]     ptr_q;
  logic           live_q;
  logic [NCH-1:0] mask_q;

  wire cmd_ch_ok = 32'(cmd_data[3:0]) < NCH;
  wire left      = live_q && (ptr_q < op_len(op_q));
  wire is_set    = (op_q == OP_PORT) || (op_q == OP_ADDR) ||
                   (op_q == OP_CNT)  || (op_q == OP_MODE);
  wire is_rd     = (op_q == OP_RADDR) || (op_q == OP_RCNT);
  wire wr_hit    = dat_we && !cmd_we && left && is_set;
  wire rd_hit    = dat_re && !cmd_we && left && is_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= 4'hF;
      ch_q   <= '0;
      ptr_q  <= '0;
      live_q <= 1'b0;
    end else if (cmd_we) begin
      op_q   <= cmd_data[7:4];
      ch_q   <= cmd_data[3:0];
      ptr_q  <= '0;
      live_q <= cmd_ch_ok;
    end else if (wr_hit || rd_hit) begin
      ptr_q  <= ptr_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '1;
    else if (cmd_we && cmd_ch_ok && cmd_data[7:4] == OP_MASK)
      mask_q[cmd_data[3:0]] <= 1'b1;
    else if (cmd_we && cmd_ch_ok && cmd_data[7:4] == OP_UNMASK)
      mask_q[cmd_data[3:0]] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      prog_err <= 1'b0;
    else if (wr_hit && !mask_q[ch_q])
      prog_err <= 1'b1;
  end

  assign ch_enable = ~mask_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [AW-1:0] a_q;
    logic [CW-1:0] c_q;
    logic [PW-1:0] p_q;
    logic [7:0]    m_q;
    wire hit = wr_hit && (32'(ch_q) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q <= '0;
        c_q <= '0;
        p_q <= '0;
        m_q <= '0;
      end else if (hit) begin
        case (op_q)
          OP_ADDR: a_q[8*ptr_q +: 8] <= dat_wdata;
          OP_CNT:  c_q[8*ptr_q[0] +: 8] <= dat_wdata;
          OP_PORT: p_q[8*ptr_q[0] +: 8] <= dat_wdata;
          OP_MODE: m_q <= dat_wdata;
          default: ;
        endcase
      end
    end

    assign ch_addr[g*AW +: AW]   = a_q;
    assign ch_count[g*CW +: CW]  = c_q;
    assign ch_ioport[g*PW +: PW] = p_q;
    assign mode_xfer[g] = m_q[2];
    assign mode_read[g] = m_q[3];
    assign mode_io[g]   = m_q[0];
    assign mode_wide[g] = m_q[6];
  end

  always_comb begin
    dat_rdata = '0;
    if (left && op_q == OP_RADDR)
      dat_rdata = ch_addr[int'(ch_q)*AW + 8*int'(ptr_q) +: 8];
    else if (left && op_q == OP_RCNT)
      dat_rdata = ch_count[int'(ch_q)*CW + 8*int'(ptr_q[0]) +: 8];
  end
endmodule

module dmacmd_regfile_chk #(parameter int NCH = 16) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_we,
  input logic [7:0]     cmd_data,
  input logic           dat_we,
  input logic [NCH-1:0] ch_enable,
  input logic [NCH-1:0] mode_xfer,
  input logic [NCH-1:0] mode_wide,
  input logic           prog_err
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ch_enable == '0 && !prog_err));

  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[7:4] == 4'h9 && 32'(cmd_data[3:0]) < NCH)
      |=> !ch_enable[$past(cmd_data[3:0])]);

  a_r7_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[7:4] == 4'hA && 32'(cmd_data[3:0]) < NCH)
      |=> ch_enable[$past(cmd_data[3:0])]);

  a_r12_enable_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(ch_enable));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |=> prog_err);

  a_r6_mode_only_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> ($stable(mode_xfer) && $stable(mode_wide)));
endmodule

bind dmacmd_regfile dmacmd_regfile_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
  .dat_we(dat_we), .ch_enable(ch_enable), .mode_xfer(mode_xfer),
  .mode_wide(mode_wide), .prog_err(prog_err));

// File: tb/test_dmacmd_regfile.sv
`timescale 1ns/1ps
module test_dmacmd_regfile;
  localparam int NCH = 16;
  logic clk = 0, rst_n = 0;
  logic cmd_we = 0, dat_we = 0, dat_re = 0;
  logic [7:0] cmd_data = 0, dat_wdata = 0, dat_rdata;
  logic [NCH-1:0] ch_enable, mode_xfer, mode_read, mode_io, mode_wide;
  logic [NCH*24-1:0] ch_addr;
  logic [NCH*16-1:0] ch_count, ch_ioport;
  logic prog_err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dmacmd_regfile i_dmacmd_regfile (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [7:0] b);
    @(negedge clk); cmd_we = 1; cmd_data = b;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); dat_we = 1; dat_wdata = b;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic rd(string req, logic [7:0] exp);
    @(negedge clk); chk(req, 32'(dat_rdata), 32'(exp)); dat_re = 1;
    @(negedge clk); dat_re = 0;
  endtask

  localparam int NV = 23;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h93, 8'h00}, {2'd0, 8'h23, 8'h00},
    {2'd1, 8'h11, 8'h00}, {2'd1, 8'h22, 8'h00}, {2'd1, 8'h33, 8'h00},
    {2'd0, 8'h33, 8'h00},
    {2'd2, 8'h00, 8'h11}, {2'd2, 8'h00, 8'h22}, {2'd2, 8'h00, 8'h33},
    {2'd2, 8'h00, 8'h00},
    {2'd0, 8'h43, 8'h00}, {2'd1, 8'hFF, 8'h00}, {2'd1, 8'hFF, 8'h00},
    {2'd1, 8'h77, 8'h00},
    {2'd0, 8'h53, 8'h00},
    {2'd2, 8'h00, 8'hFF}, {2'd2, 8'h00, 8'hFF}, {2'd2, 8'h00, 8'h00},
    {2'd0, 8'h03, 8'h00}, {2'd1, 8'h34, 8'h00}, {2'd1, 8'h12, 8'h00},
    {2'd0, 8'h73, 8'h00}, {2'd1, 8'h4D, 8'h00}
  };

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] lastop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 32'(ch_enable), 0);
    chk("R1", 32'(prog_err), 0);
    chk("R1", 32'(ch_addr[3*24 +: 24]), 0);
    chk("R1", 32'(mode_wide | mode_xfer), 0);
    chk("R1", 32'(dat_rdata), 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: begin cmd(VEC[i][15:8]); lastop = VEC[i][15:12]; end
        2'd1: wr(VEC[i][15:8]);
        default: rd(lastop == 4'h3 ? "R8" : "R9", VEC[i][7:0]);
      endcase
    end
    @(negedge clk);
    chk("R3", 32'(ch_addr[3*24 +: 24]), 32'h332211);
    chk("R4", 32'(ch_count[3*16 +: 16]), 32'hFFFF);  // R10 extra byte ignored
    chk("R10", 32'(ch_count[3*16 +: 16]), 32'hFFFF);
    chk("R5", 32'(ch_ioport[3*16 +: 16]), 32'h1234);
    chk("R6", {mode_io[3], mode_xfer[3], mode_read[3], mode_wide[3]}, 4'hF);
    chk("R11", 32'(prog_err), 0);

    cmd(8'h75); wr(8'h40); @(negedge clk);
    chk("R6", {mode_io[5], mode_xfer[5], mode_read[5], mode_wide[5]}, 4'h1);

    chk("R7", 32'(ch_enable[3]), 0);
    cmd(8'hA3); chk("R7", 32'(ch_enable[3]), 1);

    cmd(8'h23); wr(8'h99); @(negedge clk);
    chk("R11", 32'(prog_err), 1);
    chk("R11", 32'(ch_addr[3*24 +: 24]), 32'h332299);

    // R2 pointer restart on new command
    cmd(8'h23); wr(8'hAA); cmd(8'h23); wr(8'hBB); @(negedge clk);
    chk("R2", 32'(ch_addr[3*24 +: 24]), 32'h3322BB);

    // R2 command wins over same-cycle data
    @(negedge clk); cmd_we = 1; cmd_data = 8'h26; dat_we = 1; dat_wdata = 8'h55;
    @(negedge clk); cmd_we = 0; dat_we = 0;
    wr(8'h66); @(negedge clk);
    chk("R2", 32'(ch_addr[6*24 +: 24]), 32'h000066);

    // R12 unsupported opcodes
    cmd(8'h63); wr(8'h77); cmd(8'hD3); wr(8'h44); @(negedge clk);
    chk("R12", 32'(ch_addr[3*24 +: 24]), 32'h3322BB);
    chk("R12", 32'(ch_count[3*16 +: 16]), 32'hFFFF);
    chk("R12", 32'(dat_rdata), 0);
    cmd(8'h83); chk("R12", 32'(ch_enable[3]), 1);
    cmd(8'h93); chk("R7", 32'(ch_enable[3]), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule